// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block turns the synchronised values of a small port of input pins into interrupt requests. Each pin can be set up on its own to sense a level (high or low) or an edge (rising, falling, or both). Edge events are held in a per-pin latch until software clears them. Level conditions are not held: they track the pin directly. An enable mask gates each pin's status, and the enabled bits are ORed into one interrupt line.

Software reaches the block through a simple byte-wide register bus: a write strobe, a 3-bit word address, write data and a read data path. The read data path has no wait states. Reads return the control registers, the unmasked status and the masked status. A write-one-to-clear location removes latched edge events. Pin data and pin direction are handled elsewhere.

Top module: `gpio_irq_detect`

## Requirements
- R1: After a synchronous active-low reset, every control register reads 0x00, raw status reads 0x00 and `irq_o` is low.
- R2: Writes take effect at the next clock edge and read back unchanged at these addresses: 0 sense (1 = level, 0 = edge), 1 both-edge, 2 polarity, 3 enable.
- R3: A level-sensed pin shows raw status equal to the pin when polarity is 1, and equal to the inverted pin when polarity is 0. The status follows the pin in the same cycle and is not latched.
- R4: An edge-sensed pin with both-edge 0 latches on a rising edge when polarity is 1 and on a falling edge when polarity is 0. Raw status rises at the first clock edge after the pin changes.
- R5: When both-edge is 1 on an edge-sensed pin, rising and falling edges both latch, whatever the polarity bit holds.
- R6: A latched edge stays set after the pin returns, until a write to address 6 with a 1 in that pin's bit. Zero bits in that write leave the other latches as they are. Level status is not affected by this write.
- R7: If a new edge on a pin and a clear for the same pin arrive in the same cycle, the latch stays set.
- R8: Address 4 reads raw status. Address 5 reads masked status, which is raw status ANDed with enable.
- R9: `irq_o` is high exactly when any masked status bit is 1.
- R10: Addresses 6 and 7 read as 0x00. Writes to addresses 4, 5 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Synchronised pin values |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Any corruption of a latch shows up on the raw and masked status reads and on `irq_o`. A latch that drops out early, sets without cause, or survives a clear is visible one clock after the event or clear that should have decided it. Any corruption of the previous-pin register shows up as a missed or extra edge latch at the next clock edge. Errors in the level path or the masking are purely combinational and visible in the same cycle. For that reason the bench reads status two cycles after each stimulus, and it reads level status in the same cycle.

// File: rtl/gpio_irq_pkg.sv
// Package: shared address map for the GPIO interrupt detector.
// Assumes a 3-bit word address on the register bus.
package gpio_irq_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_SENSE  = 3'd0,
        A_BOTH   = 3'd1,
        A_POL    = 3'd2,
        A_ENABLE = 3'd3,
        A_RAW    = 3'd4,
        A_MASKED = 3'd5,
        A_CLEAR  = 3'd6,
        A_SPARE  = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
// Module: control register file for the interrupt detector.
// Holds sense, both-edge, polarity and enable, and turns writes to the clear
// address into a one-cycle clear pulse. Assumes a synchronous active-low reset.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N-1:0]      reg_wdata,
    output logic [N-1:0]      sense_q,
    output logic [N-1:0]      both_q,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      enable_q,
    output logic [N-1:0]      clr_pulse
);
    // Register update: reset to zero, load on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q  <= '0;
            both_q   <= '0;
            pol_q    <= '0;
            enable_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                A_SENSE:  sense_q  <= reg_wdata;
                A_BOTH:   both_q   <= reg_wdata;
                A_POL:    pol_q    <= reg_wdata;
                A_ENABLE: enable_q <= reg_wdata;
                default:  ;
            endcase
        end
    end

    // Clear pulse: write data at the clear address, else nothing.
    always_comb begin
        clr_pulse = (reg_we && reg_addr == A_CLEAR) ? reg_wdata : '0;
    end

    AST_CFG_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (sense_q == '0 && both_q == '0 && pol_q == '0 && enable_q == '0)); // R1

    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == A_RAW || reg_addr == A_MASKED || reg_addr == A_SPARE))
        |=> ($stable(sense_q) && $stable(both_q) && $stable(pol_q) && $stable(enable_q))); // R10
endmodule

// File: rtl/gpio_irq_edge.sv
// Module: per-pin edge finder.
// Keeps last cycle's pin value and flags the edges that the pin's
// configuration asks for. Assumes pin_i is already synchronised.
module gpio_irq_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic [N-1:0] pin_i,
    input  logic [N-1:0] sense_q,
    input  logic [N-1:0] both_q,
    input  logic [N-1:0] pol_q,
    output logic [N-1:0] edge_evt
);
    logic [N-1:0] prev_q;

    // Previous-value register: one cycle of pin history.
    always_ff @(posedge clk) begin
        prev_q <= pin_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic rise, fall;
        // Edge selection: both-edge overrides polarity; level pins give none.
        always_comb begin
            rise = pin_i[i] & ~prev_q[i];
            fall = ~pin_i[i] & prev_q[i];
            if (sense_q[i])
                edge_evt[i] = 1'b0;
            else if (both_q[i])
                edge_evt[i] = rise | fall;
            else
                edge_evt[i] = pol_q[i] ? rise : fall;
        end
    end
endmodule

// File: rtl/gpio_irq_latch.sv
// Module: edge event latches with write-one-to-clear.
// A new event in the same cycle as a clear keeps the bit set.
// Assumes a synchronous active-low reset.
module gpio_irq_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] edge_evt,
    input  logic [N-1:0] clr_pulse,
    output logic [N-1:0] latch_q
);
    // Latch update: set by events, cleared by ones in the clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else
            latch_q <= (latch_q & ~clr_pulse) | edge_evt;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_q[i] && !clr_pulse[i]) |=> latch_q[i]); // R6
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_pulse[i] && !edge_evt[i]) |=> !latch_q[i]); // R6
        AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            edge_evt[i] |=> latch_q[i]); // R7
        AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!latch_q[i] && !edge_evt[i]) |=> !latch_q[i]); // R4
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Module: top of the GPIO interrupt detector.
// Combines level status and edge latches into raw status, masks with enable,
// drives the OR'ed interrupt and the combinational read path.
// Assumes synchronised pins and a synchronous active-low reset.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      pin_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N-1:0]      reg_wdata,
    output logic [N-1:0]      reg_rdata,
    output logic              irq_o
);
    logic [N-1:0] sense_q, both_q, pol_q, enable_q, clr_pulse;
    logic [N-1:0] edge_evt, latch_q;
    logic [N-1:0] level_hit, raw_st, masked_st;

    gpio_irq_cfg #(.N(N)) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .sense_q(sense_q), .both_q(both_q),
        .pol_q(pol_q), .enable_q(enable_q), .clr_pulse(clr_pulse)
    );

    gpio_irq_edge #(.N(N)) u_edge (
        .clk(clk), .pin_i(pin_i), .sense_q(sense_q), .both_q(both_q),
        .pol_q(pol_q), .edge_evt(edge_evt)
    );

    gpio_irq_latch #(.N(N)) u_latch (
        .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt),
        .clr_pulse(clr_pulse), .latch_q(latch_q)
    );

    // Status: level pins follow the pin, edge pins show their latch.
    always_comb begin
        level_hit = ~(pin_i ^ pol_q);
        raw_st    = (sense_q & level_hit) | (~sense_q & latch_q);
        masked_st = raw_st & enable_q;
        irq_o     = |masked_st;
    end

    // Read path: zero-wait-state mux over the address map.
    always_comb begin
        case (reg_addr)
            A_SENSE:  reg_rdata = sense_q;
            A_BOTH:   reg_rdata = both_q;
            A_POL:    reg_rdata = pol_q;
            A_ENABLE: reg_rdata = enable_q;
            A_RAW:    reg_rdata = raw_st;
            A_MASKED: reg_rdata = masked_st;
            default:  reg_rdata = '0;
        endcase
    end

    AST_IRQ_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> !irq_o); // R9
    AST_IRQ_LOW_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> !irq_o); // R1
endmodule

// File: tb/tb_gpio_irq_detect.sv
`timescale 1ns/1ps
module tb_gpio_irq_detect;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_i = '0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = 3'd0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    gpio_irq_detect #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o)
    );

    // Vector: {sense, pol, both, pin_before, pin_after, expected_raw}
    localparam logic [5:0] VEC [11] = '{
        6'b110011, 6'b110100, 6'b100010, 6'b100101,
        6'b010011, 6'b010100, 6'b000101, 6'b000010,
        6'b011011, 6'b001101, 6'b001000
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(a[2:0], d);
            check("R1 reset reg", d, 8'h00);
        end
        check("R1 irq reset", {7'b0, irq_o}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // R2 readback
        wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'h96); wr(3'd3, 8'h5A);
        rd(3'd0, d); check("R2 sense", d, 8'hA5);
        rd(3'd1, d); check("R2 both", d, 8'h3C);
        rd(3'd2, d); check("R2 pol", d, 8'h96);
        rd(3'd3, d); check("R2 enable", d, 8'h5A);

        // Vector table: R3 level, R4 single edge, R5 both edges, R8/R9 status
        wr(3'd3, 8'hFF);
        foreach (VEC[k]) begin
            logic [5:0] v;
            v = VEC[k];
            @(negedge clk); pin_i = {N{v[2]}};
            wr(3'd0, {N{v[5]}}); wr(3'd2, {N{v[4]}}); wr(3'd1, {N{v[3]}});
            wr(3'd6, 8'hFF);
            pin_i = {N{v[1]}};
            @(negedge clk); @(negedge clk);
            rd(3'd4, d);
            check(v[5] ? "R3 level raw" : (v[3] ? "R5 both raw" : "R4 edge raw"), d, {N{v[0]}});
            rd(3'd5, d); check("R8 masked", d, {N{v[0]}});
            check("R9 irq", {7'b0, irq_o}, {7'b0, v[0]});
        end

        // R4/R6 hold after pin returns, partial clear
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'hFF);
        @(negedge clk); pin_i = 8'h00;
        wr(3'd6, 8'hFF);
        pin_i = 8'hFF; @(negedge clk); pin_i = 8'h00; @(negedge clk);
        rd(3'd4, d); check("R6 latch holds", d, 8'hFF);
        wr(3'd6, 8'h0F);
        rd(3'd4, d); check("R6 partial clear", d, 8'hF0);

        // R8 masked and R9 irq with mask
        wr(3'd6, 8'hFF); @(negedge clk);
        pin_i = 8'hFF; @(negedge clk); @(negedge clk);
        wr(3'd3, 8'h3C);
        rd(3'd5, d); check("R8 masked subset", d, 8'h3C);
        check("R9 irq on", {7'b0, irq_o}, 8'h01);
        wr(3'd3, 8'h00);
        check("R9 irq off when disabled", {7'b0, irq_o}, 8'h00);

        // R10 status writes ignored, clear/spare read zero
        wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd7, 8'h00);
        rd(3'd4, d); check("R10 raw unchanged", d, 8'hFF);
        rd(3'd3, d); check("R10 enable unchanged", d, 8'h00);
        rd(3'd6, d); check("R10 clear reads 0", d, 8'h00);
        rd(3'd7, d); check("R10 spare reads 0", d, 8'h00);

        // R7 edge coincident with clear
        pin_i = 8'h00; @(negedge clk);
        wr(3'd6, 8'hFF);
        rd(3'd4, d); check("R7 pre-clear", d, 8'h00);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 8'hFF; pin_i = 8'hFF;
        @(negedge clk); reg_we = 1'b0;
        rd(3'd4, d); check("R7 edge wins", d, 8'hFF);

        // R3 level follows pin same cycle; R6 clear has no effect on level
        wr(3'd0, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        pin_i = 8'h0F; rd(3'd4, d); check("R3 level same cycle", d, 8'h0F);
        wr(3'd6, 8'hFF);
        rd(3'd4, d); check("R6 level unaffected by clear", d, 8'h0F);
        pin_i = 8'h00; rd(3'd4, d); check("R3 level drops", d, 8'h00);
        check("R9 irq level drop", {7'b0, irq_o}, 8'h00);

        // R1 re-reset clears config and irq
        pin_i = 8'hFF; #1;
        @(negedge clk); rst_n = 1'b0; @(negedge clk); @(negedge clk);
        rd(3'd0, d); check("R1 re-reset sense", d, 8'h00);
        check("R1 re-reset irq", {7'b0, irq_o}, 8'h00);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule